// File: doc/BRIEF.md
# Receive Frame Aligner and Short-Frame Filter

This block sits in a byte-wide receive path, between the stage that recovers frames from the medium and the stage that writes them into memory. It passes each frame through unchanged in length and content, except for two optional behaviours. In alignment mode it emits a fixed number of filler bytes (two by default, value 0x00) ahead of the first destination-address byte. After a 14-byte header, the payload then starts on a 4-byte boundary of the receive buffer. The runt filter marks any frame shorter than a minimum length (64 bytes by default) as dropped. A control bit lets such frames through instead.

Frames stream through without buffering. At the last output byte of a frame the block raises either a one-cycle accept strobe or a one-cycle drop strobe. On accept it presents the frame's byte count, and that count never includes the fillers. The buffer stage uses the drop strobe to discard what it has already written. Two control bits, the alignment enable and the runt acceptance, are set through a small register write port. A stop input gates writes to the runt acceptance bit. A hardware reset and a software reset both clear the two bits.

Top module: `rx_frame_shaper`

## Requirements
- R1: With alignment enabled at a frame's first input byte, the output carries PAD_BYTES (2) bytes of value 0x00, then every input byte in order. The first filler appears one cycle after the first input byte, and byte k of a back-to-back input frame appears PAD_BYTES+1 cycles after it was presented.
- R2: With alignment disabled, every input byte appears at the output unchanged, exactly one cycle after it is presented, with outLast on the copy of the input's last byte only.
- R3: On an accepted frame, frameDone pulses with the final output byte, and frameCount then holds the number of input bytes of the frame. Fillers are not counted.
- R4: A frame with fewer than MIN_LEN (64) input bytes while runt acceptance is clear raises frameDrop with its final output byte. It raises no frameDone, and frameCount keeps its previous value.
- R5: With runt acceptance set, frames shorter than MIN_LEN are accepted as in R3.
- R6: A frame of MIN_LEN or more input bytes is always accepted, whatever runt acceptance is set to. The filler bytes never count toward the length test.
- R7: A write (regWrEn=1) always loads regWrData[0] into the alignment enable, regardless of stopState. regRdData[0] returns it on the next cycle.
- R8: A write loads regWrData[1] into runt acceptance only when stopState=1. Otherwise that bit keeps its value. regRdData[1] returns it.
- R9: rstN low or swReset high clears both control bits to 0 and empties the datapath. A change of stopState without a write changes neither bit.
- R10: Alignment is sampled once per frame, at its first input byte. A write that changes it in mid-frame affects only later frames.
- R11: frameDone and frameDrop are never high together, and either one is high only together with outValid and outLast.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, asynchronous, active low |
| swReset | input | 1 | Software reset, synchronous, active high |
| stopState | input | 1 | High while the controller is stopped; enables runt-acceptance writes |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 2 | Bit 0 alignment enable, bit 1 runt acceptance |
| regRdData | output | 2 | Current control bits, same layout as regWrData |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inLast | input | 1 | Input byte is the last of its frame |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte (filler or frame byte) |
| outLast | output | 1 | Output byte is the last of its frame |
| frameDone | output | 1 | Frame accepted, one cycle, with the last output byte |
| frameDrop | output | 1 | Frame rejected as runt, one cycle, with the last output byte |
| frameCount | output | 16 | Byte count of the most recently accepted frame |

## Verification
Internal state errors show up at the ports within one frame. A wrong per-frame alignment latch or filler counter changes how many bytes a frame produces, and it moves every later byte by whole cycles. This is visible from the first output cycle of the frame. A wrong byte counter, or a length test that includes the fillers, shows up at the last byte, as a wrong frameCount or a strobe on the wrong side of the 63/64-byte boundary. The bench therefore sweeps every length from 1 to 70 in all four mode combinations and checks each byte's value and arrival cycle against arithmetic expectations. Register-rule errors show up in regRdData one cycle after the offending write or reset.

// File: rtl/rxshp_pkg.sv
package rxshp_pkg;

  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic             fill;     // emit one filler byte this cycle
    logic             direct;   // forward input byte with single-cycle latency
    logic             delayIn;  // push input byte into the delay line
    logic             endOk;    // input byte closes an accepted frame
    logic             endDrop;  // input byte closes a rejected frame
    logic [CNT_W-1:0] len;      // frame length including the current byte
  } strobe_t;

  // One slot of the alignment delay line
  typedef struct packed {
    logic              valid;
    logic [BYTE_W-1:0] data;
    logic              last;
    logic              ok;
    logic              drop;
    logic [CNT_W-1:0]  len;
  } lane_t;

endpackage

// File: rtl/rxshp_ctrl.sv
module rxshp_ctrl
  import rxshp_pkg::*;
#(
  parameter int MIN_LEN   = 64,
  parameter int PAD_BYTES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       swReset,
  input  logic       stopState,
  input  logic       regWrEn,
  input  logic [1:0] regWrData,
  input  logic       inValid,
  input  logic       inLast,
  output logic       alignEn,
  output logic       runtAcc,
  output strobe_t    stb
);

  localparam int               FILL_W    = $clog2(PAD_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] MIN_LEN_C = CNT_W'(MIN_LEN);
  localparam logic [FILL_W-1:0] FILL_RST = FILL_W'(PAD_BYTES - 1);

  logic              inFrame;
  logic              frameAlign;
  logic [CNT_W-1:0]  byteCnt;
  logic [FILL_W-1:0] fillLeft;

  logic              sof;
  logic              curAlign;
  logic [CNT_W-1:0]  curCnt;
  logic [CNT_W-1:0]  lenNow;
  logic              endHit;
  logic              isRunt;

  // Control bits: alignment always writable, runt acceptance only when stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alignEn <= 1'b0;
      runtAcc <= 1'b0;
    end else if (swReset) begin
      alignEn <= 1'b0;
      runtAcc <= 1'b0;
    end else if (regWrEn) begin
      alignEn <= regWrData[0];
      if (stopState) runtAcc <= regWrData[1];
    end
  end

  always_comb begin
    sof      = inValid && !inFrame;
    curAlign = sof ? alignEn : frameAlign;
    curCnt   = sof ? '0 : byteCnt;
    lenNow   = (curCnt == CNT_MAX) ? CNT_MAX : curCnt + 1'b1;
    endHit   = inValid && inLast;
    isRunt   = lenNow < MIN_LEN_C;

    stb         = '0;
    stb.fill    = (sof && alignEn) || (fillLeft != '0);
    stb.direct  = inValid && !curAlign;
    stb.delayIn = inValid && curAlign;
    stb.endOk   = endHit && !(isRunt && !runtAcc);
    stb.endDrop = endHit && isRunt && !runtAcc;
    stb.len     = lenNow;
  end

  // Per-frame tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame    <= 1'b0;
      frameAlign <= 1'b0;
      byteCnt    <= '0;
      fillLeft   <= '0;
    end else if (swReset) begin
      inFrame    <= 1'b0;
      frameAlign <= 1'b0;
      byteCnt    <= '0;
      fillLeft   <= '0;
    end else begin
      if (inValid) begin
        inFrame <= !inLast;
        byteCnt <= lenNow;
      end
      if (sof) frameAlign <= alignEn;
      if (sof && alignEn)      fillLeft <= FILL_RST;
      else if (fillLeft != '0) fillLeft <= fillLeft - 1'b1;
    end
  end

endmodule

// File: rtl/rxshp_datapath.sv
module rxshp_datapath
  import rxshp_pkg::*;
#(
  parameter int               PAD_BYTES = 2,
  parameter logic [BYTE_W-1:0] FILL_BYTE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReset,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outLast,
  output logic              frameDone,
  output logic              frameDrop,
  output logic [CNT_W-1:0]  frameCount
);

  lane_t laneIn;
  lane_t stage [PAD_BYTES];
  lane_t tail;

  always_comb begin
    laneIn       = '0;
    laneIn.valid = stb.delayIn;
    laneIn.data  = inData;
    laneIn.last  = stb.delayIn && inLast;
    laneIn.ok    = stb.delayIn && stb.endOk;
    laneIn.drop  = stb.delayIn && stb.endDrop;
    laneIn.len   = stb.len;
  end

  // Delay line that shifts every cycle, PAD_BYTES deep
  for (genvar g = 0; g < PAD_BYTES; g++) begin : gDelay
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        stage[g] <= '0;
      else if (swReset) stage[g] <= '0;
      else if (g == 0)  stage[g] <= laneIn;
      else              stage[g] <= stage[(g == 0) ? 0 : g - 1];
    end
  end

  assign tail = stage[PAD_BYTES-1];

  // Output register: filler has priority, then delayed bytes, then direct bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outData    <= '0;
      outLast    <= 1'b0;
      frameDone  <= 1'b0;
      frameDrop  <= 1'b0;
      frameCount <= '0;
    end else if (swReset) begin
      outValid   <= 1'b0;
      outData    <= '0;
      outLast    <= 1'b0;
      frameDone  <= 1'b0;
      frameDrop  <= 1'b0;
      frameCount <= '0;
    end else if (stb.fill) begin
      outValid  <= 1'b1;
      outData   <= FILL_BYTE;
      outLast   <= 1'b0;
      frameDone <= 1'b0;
      frameDrop <= 1'b0;
    end else if (tail.valid) begin
      outValid  <= 1'b1;
      outData   <= tail.data;
      outLast   <= tail.last;
      frameDone <= tail.ok;
      frameDrop <= tail.drop;
      if (tail.ok) frameCount <= tail.len;
    end else if (stb.direct) begin
      outValid  <= 1'b1;
      outData   <= inData;
      outLast   <= inLast;
      frameDone <= stb.endOk;
      frameDrop <= stb.endDrop;
      if (stb.endOk) frameCount <= stb.len;
    end else begin
      outValid  <= 1'b0;
      outData   <= '0;
      outLast   <= 1'b0;
      frameDone <= 1'b0;
      frameDrop <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_frame_shaper.sv
module rx_frame_shaper
  import rxshp_pkg::*;
#(
  parameter int               MIN_LEN   = 64,
  parameter int               PAD_BYTES = 2,
  parameter logic [BYTE_W-1:0] FILL_BYTE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReset,
  input  logic              stopState,
  input  logic              regWrEn,
  input  logic [1:0]        regWrData,
  output logic [1:0]        regRdData,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outLast,
  output logic              frameDone,
  output logic              frameDrop,
  output logic [CNT_W-1:0]  frameCount
);

  strobe_t stb;
  logic    alignEn;
  logic    runtAcc;

  assign regRdData = {runtAcc, alignEn};

  rxshp_ctrl #(
    .MIN_LEN  (MIN_LEN),
    .PAD_BYTES(PAD_BYTES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .swReset  (swReset),
    .stopState(stopState),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .inValid  (inValid),
    .inLast   (inLast),
    .alignEn  (alignEn),
    .runtAcc  (runtAcc),
    .stb      (stb)
  );

  rxshp_datapath #(
    .PAD_BYTES(PAD_BYTES),
    .FILL_BYTE(FILL_BYTE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .swReset   (swReset),
    .stb       (stb),
    .inData    (inData),
    .inLast    (inLast),
    .outValid  (outValid),
    .outData   (outData),
    .outLast   (outLast),
    .frameDone (frameDone),
    .frameDrop (frameDrop),
    .frameCount(frameCount)
  );

endmodule

// File: rtl/rxshp_checker.sv
module rxshp_checker (
  input logic       clk,
  input logic       rstN,
  input logic       swReset,
  input logic       stopState,
  input logic       regWrEn,
  input logic [1:0] regWrData,
  input logic [1:0] regRdData,
  input logic       inValid,
  input logic       inLast,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outLast,
  input logic       frameDone,
  input logic       frameDrop
);

  logic chkInFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        chkInFrame <= 1'b0;
    else if (swReset) chkInFrame <= 1'b0;
    else if (inValid) chkInFrame <= !inLast;
  end

  AST_FIRST_FILLER: assert property (@(posedge clk) disable iff (!rstN || swReset)
    (inValid && !chkInFrame && regRdData[0]) |=> (outValid && outData == 8'h00 && !outLast)); // R1

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rstN || swReset)
    !(frameDone && frameDrop)); // R11

  AST_STATUS_AT_LAST: assert property (@(posedge clk) disable iff (!rstN || swReset)
    (frameDone || frameDrop) |-> (outValid && outLast)); // R11

  AST_ALIGN_WRITE: assert property (@(posedge clk) disable iff (!rstN || swReset)
    regWrEn |=> (regRdData[0] == $past(regWrData[0]))); // R7

  AST_RUNT_LOCKED: assert property (@(posedge clk) disable iff (!rstN || swReset)
    (regWrEn && !stopState) |=> $stable(regRdData[1])); // R8

  AST_BITS_HOLD: assert property (@(posedge clk) disable iff (!rstN || swReset)
    !regWrEn |=> $stable(regRdData)); // R9

  AST_SWRESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (regRdData == 2'b00 && !outValid)); // R9

endmodule

bind rx_frame_shaper rxshp_checker u_chk (.*);

// File: tb/sim_rx_frame_shaper.sv
module sim_rx_frame_shaper;

  localparam int CLK_PERIOD = 10;
  localparam int PAD        = 2;
  localparam int MINL       = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       swReset = 1'b0;
  logic       stopState = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regWrData = 2'b00;
  logic [1:0] regRdData;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inLast = 1'b0;
  logic       outValid;
  logic [7:0] outData;
  logic       outLast;
  logic       frameDone;
  logic       frameDrop;
  logic [15:0] frameCount;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // monitor storage
  logic [7:0] capData [128];
  int         capCyc  [128];
  logic       capLast [128];
  int capIdx    = 0;
  int doneSeen  = 0;
  int dropSeen  = 0;
  int statusIdx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_shaper u0 (
    .clk(clk), .rstN(rstN), .swReset(swReset), .stopState(stopState),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .inValid(inValid), .inData(inData), .inLast(inLast),
    .outValid(outValid), .outData(outData), .outLast(outLast),
    .frameDone(frameDone), .frameDrop(frameDrop), .frameCount(frameCount)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (outValid) begin
      capData[capIdx % 128] = outData;
      capCyc[capIdx % 128]  = cyc;
      capLast[capIdx % 128] = outLast;
      if (frameDone) begin doneSeen = doneSeen + 1; statusIdx = capIdx; end
      if (frameDrop) begin dropSeen = dropSeen + 1; statusIdx = capIdx; end
      capIdx = capIdx + 1;
    end
  end

  task automatic chk(input bit cond, input string tag, input string what,
                     input longint act, input longint exp);
    checks = checks + 1;
    if (!cond) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int len, input int i);
    return 8'(len * 29 + i * 11) | 8'h01;
  endfunction

  task automatic wrReg(input bit stop, input logic [1:0] val);
    @(negedge clk);
    stopState = stop;
    regWrEn   = 1'b1;
    regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic runFrame(input int len, input bit al, input bit ra, input bit flip);
    int base = capIdx;
    int doneBase = dropSeen * 0 + doneSeen;
    int dropBase = dropSeen;
    int d0 = 0;
    int n;
    int badData = 0;
    int badCyc = 0;
    int badLast = 0;
    bit ok;
    logic [15:0] cntBefore = frameCount;
    string mtag;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) d0 = cyc;
      inValid = 1'b1;
      inData  = pat(len, i);
      inLast  = (i == len - 1);
      if (flip && i == 2) begin
        regWrEn   = 1'b1;
        regWrData = {ra, ~al};
      end else begin
        regWrEn = 1'b0;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
    regWrEn = 1'b0;
    repeat (5) @(negedge clk);

    n    = len + (al ? PAD : 0);
    ok   = (len >= MINL) || ra;
    mtag = al ? (flip ? "R10" : "R1") : (flip ? "R10" : "R2");
    chk(capIdx - base == n, mtag, "output byte count", capIdx - base, n);
    for (int k = 0; k < n && k < 128; k++) begin
      logic [7:0] e;
      int idx = (base + k) % 128;
      if (al && k < PAD) e = 8'h00;
      else               e = pat(len, k - (al ? PAD : 0));
      if (capData[idx] !== e)      badData++;
      if (capCyc[idx] != d0 + k + 1) badCyc++;
      if (capLast[idx] !== (k == n - 1)) badLast++;
    end
    chk(badData == 0, mtag, "mismatched bytes", badData, 0);
    chk(badCyc == 0, mtag, "bytes at wrong cycle", badCyc, 0);
    chk(badLast == 0, mtag, "wrong outLast flags", badLast, 0);
    chk(statusIdx == base + n - 1, "R11", "status byte index", statusIdx - base, n - 1);
    if (ok) begin
      mtag = (len < MINL) ? "R5" : "R6";
      chk(doneSeen - doneBase == 1 && dropSeen == dropBase, mtag, "accept strobes",
          doneSeen - doneBase, 1);
      chk(frameCount == 16'(len), "R3", "frameCount", frameCount, len);
    end else begin
      chk(dropSeen - dropBase == 1 && doneSeen == doneBase, "R4", "drop strobes",
          dropSeen - dropBase, 1);
      chk(frameCount == cntBefore, "R4", "frameCount held", frameCount, cntBefore);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(regRdData == 2'b00, "R9", "control bits after reset", regRdData, 0);
    chk(outValid == 1'b0 && frameDone == 1'b0 && frameDrop == 1'b0, "R9", "outputs idle after reset",
        outValid, 0);
    chk(frameCount == 16'd0, "R9", "frameCount after reset", frameCount, 0);

    // R7, R8: write while running: only align bit lands
    wrReg(1'b0, 2'b11);
    chk(regRdData == 2'b01, "R8", "runt bit write while running", regRdData, 1);
    // R8, R7: write while stopped: both land, align clears
    wrReg(1'b1, 2'b10);
    chk(regRdData == 2'b10, "R8", "write while stopped", regRdData, 2);
    wrReg(1'b0, 2'b01);
    chk(regRdData == 2'b11, "R7", "align write while running", regRdData, 3);
    // R9: stop toggling without write changes nothing
    @(negedge clk); stopState = 1'b1;
    @(negedge clk); stopState = 1'b0;
    @(negedge clk);
    chk(regRdData == 2'b11, "R9", "stop change alone", regRdData, 3);
    // R9: software reset clears
    @(negedge clk); swReset = 1'b1;
    @(negedge clk); swReset = 1'b0;
    chk(regRdData == 2'b00, "R9", "software reset clears bits", regRdData, 0);
    wrReg(1'b1, 2'b11);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk(regRdData == 2'b00, "R9", "hardware reset clears bits", regRdData, 0);

    // Sweep all mode combinations and lengths 1..70
    for (int m = 0; m < 4; m++) begin
      bit al = m[0];
      bit ra = m[1];
      wrReg(1'b1, {ra, al});
      @(negedge clk); stopState = 1'b0;
      for (int len = 1; len <= 70; len++) runFrame(len, al, ra, 1'b0);
    end

    // R10: mid-frame flips of alignment; latched value holds for the frame
    for (int m = 0; m < 2; m++) begin
      bit al = m[0];
      wrReg(1'b1, {1'b0, al});
      runFrame(10, al, 1'b0, 1'b1);
      chk(regRdData[0] == ~al, "R10", "mid-frame write took effect", regRdData[0], ~al);
      runFrame(65, ~al, 1'b0, 1'b0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule